// File: doc/BRIEF.md
# VCO Calibration Sequencer

This block runs the band calibration of an integer-N synthesizer's VCO from a software control bit. A calibration starts when the calibrate bit goes from 0 to 1. The block then captures the N2 and M1 divider settings and the reference doubler setting, and drives a calibration feedback divider equal to their product. If the doubler is on and the product is too small for the calibration divider, the block turns the doubler off for the run and doubles the divider value instead.

The calibration is timed in phase-detector ticks. After it, the block turns the doubler back on, fires a one-cycle sync pulse to the output dividers and waits out a lock budget, also counted in phase-detector ticks. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end. From reset until the first sync, the outputs fed by the VCO are held in sync.

Top module: `vco_cal_seq`

## Requirements
- R1: A run starts only when `cal_req` is 1 after being 0 at the previous clock edge while the block is idle. A level held at 1 (also across reset release) does not start a run. A 0-to-1 edge during a run is ignored.
- R2: From the second cycle of a run, `cal_div` equals `n2_div` × `m1_div` as captured at the start, and it holds that value until the next run.
- R3: When the captured doubler setting is 1 and the product is below `MIN_DIV` (16), `dbl_en` is 0 from the second cycle of the run until the sync cycle, and `cal_div` is twice the product. When the captured setting is 0 or the product is 16 or more, there is no bypass.
- R4: `cal_busy` rises in the cycle after the starting edge and stays 1 until the sequence ends.
- R5: The calibration phase consumes exactly `CAL_TICKS` cycles in which `pfd_tick` is 1. Cycles without a tick stretch the phase. With `pfd_tick` always 1, `cal_busy` is high for `CAL_TICKS` + L + 4 cycles, where L is `lock_wait_cfg`.
- R6: `sync_pulse` is 1 for exactly one cycle per run, `CAL_TICKS` + 2 cycles after `cal_busy` rises (with no tick gaps). In that same cycle `dbl_en` returns to the captured doubler setting.
- R7: `hold_sync` is 1 after reset and falls with the first `sync_pulse`. Later runs never raise it again.
- R8: After the sync cycle the block waits for `lock_wait_cfg` pfd ticks, with the value taken at the sync cycle, before it ends the run.
- R9: `cal_done` is a one-cycle pulse in the first cycle in which `cal_busy` is 0 again.
- R10: Changes to `n2_div`, `m1_div` or `dbl_en_cfg` during a run do not change `cal_div` or the doubler value that is restored at the end.
- R11: While idle, `dbl_en` follows `dbl_en_cfg` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_req | input | 1 | Software calibrate bit (level) |
| n2_div | input | N2_W | N2 feedback divide setting |
| m1_div | input | M1_W | M1 VCO divide setting |
| dbl_en_cfg | input | 1 | Configured reference doubler enable |
| pfd_tick | input | 1 | One pulse per phase-detector period |
| lock_wait_cfg | input | LOCK_W | Lock budget in pfd ticks |
| cal_div | output | N2_W+M1_W+1 | Calibration feedback divider value |
| dbl_en | output | 1 | Doubler enable sent to the reference path |
| cal_busy | output | 1 | Sequence in progress |
| sync_pulse | output | 1 | One-cycle output divider sync request |
| hold_sync | output | 1 | Hold VCO-fed outputs in sync |
| cal_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the following on every cycle: the start condition against the history of `cal_req`, the one-cycle width of the sync and done pulses, that sync happens only while busy, that `hold_sync` never returns once it drops, and that `cal_div` stays stable during a run. Only the bench scenarios can show the rest. These are the divider and bypass values computed from random and boundary settings (products of 15, 16 and 30), the exact positions of sync and done, and the stretch of the run caused by tick gaps. They also cover ignored edges and level holds, settings changed during a run, and the idle tracking of the doubler.

// File: rtl/vco_cal_pkg.sv
package vco_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_CAL     = 3'd2,
    ST_RESTORE = 3'd3,
    ST_SYNC    = 3'd4,
    ST_LOCK    = 3'd5
  } cal_state_e;
endpackage

// File: rtl/vco_cal_edge.sv
module vco_cal_edge (
  input  logic clk,
  input  logic level_in,
  output logic rise
);
  logic level_q;
  // Follows the input through reset as well, so a level held across reset is not an edge.
  always_ff @(posedge clk) level_q <= level_in;
  assign rise = level_in & ~level_q;
endmodule

// File: rtl/vco_cal_divplan.sv
module vco_cal_divplan #(
  parameter int N2_W    = 8,
  parameter int M1_W    = 3,
  parameter int DIV_W   = N2_W + M1_W + 1,
  parameter int MIN_DIV = 16
) (
  input  logic [N2_W-1:0]  n2,
  input  logic [M1_W-1:0]  m1,
  input  logic             dbl_cfg,
  output logic [DIV_W-1:0] div,
  output logic             bypass
);
  logic [DIV_W-1:0] prod;
  assign prod   = DIV_W'(n2) * DIV_W'(m1);
  assign bypass = dbl_cfg && (prod < DIV_W'(MIN_DIV));
  assign div    = bypass ? (prod << 1) : prod;
endmodule

// File: rtl/vco_cal_counter.sv
module vco_cal_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end
  assign is_zero = (cnt == '0);
endmodule

// File: rtl/vco_cal_seq.sv
module vco_cal_seq
  import vco_cal_pkg::*;
#(
  parameter int N2_W      = 8,
  parameter int M1_W      = 3,
  parameter int CAL_TICKS = 400000,
  parameter int LOCK_W    = 20,
  parameter int MIN_DIV   = 16,
  localparam int DIV_W    = N2_W + M1_W + 1,
  localparam int CAL_W    = (CAL_TICKS > 1) ? $clog2(CAL_TICKS) : 1,
  localparam int CNT_W    = (CAL_W > LOCK_W) ? CAL_W : LOCK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_req,
  input  logic [N2_W-1:0]   n2_div,
  input  logic [M1_W-1:0]   m1_div,
  input  logic              dbl_en_cfg,
  input  logic              pfd_tick,
  input  logic [LOCK_W-1:0] lock_wait_cfg,
  output logic [DIV_W-1:0]  cal_div,
  output logic              dbl_en,
  output logic              cal_busy,
  output logic              sync_pulse,
  output logic              hold_sync,
  output logic              cal_done
);
  cal_state_e state;
  logic start;
  logic [N2_W-1:0] n2_lat;
  logic [M1_W-1:0] m1_lat;
  logic dbl_lat;
  logic [DIV_W-1:0] plan_div;
  logic plan_bypass;
  logic cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  vco_cal_edge u_edge (.clk(clk), .level_in(cal_req), .rise(start));

  vco_cal_divplan #(.N2_W(N2_W), .M1_W(M1_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_plan (
    .n2(n2_lat), .m1(m1_lat), .dbl_cfg(dbl_lat), .div(plan_div), .bypass(plan_bypass)
  );

  // One counter serves both the calibration and the lock-wait phase.
  assign cnt_load = (state == ST_SETUP) || (state == ST_RESTORE);
  assign cnt_val  = (state == ST_SETUP) ? CNT_W'(CAL_TICKS - 1) : CNT_W'(lock_wait_cfg);
  assign cnt_dec  = pfd_tick && ((state == ST_CAL) || (state == ST_LOCK));

  vco_cal_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .dec(cnt_dec), .is_zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      n2_lat     <= '0;
      m1_lat     <= '0;
      dbl_lat    <= 1'b0;
      cal_div    <= '0;
      dbl_en     <= 1'b0;
      cal_busy   <= 1'b0;
      sync_pulse <= 1'b0;
      hold_sync  <= 1'b1;
      cal_done   <= 1'b0;
    end else begin
      sync_pulse <= 1'b0;
      cal_done   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          dbl_en <= dbl_en_cfg;
          if (start) begin
            n2_lat   <= n2_div;
            m1_lat   <= m1_div;
            dbl_lat  <= dbl_en_cfg;
            cal_busy <= 1'b1;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cal_div <= plan_div;
          dbl_en  <= dbl_lat & ~plan_bypass;
          state   <= ST_CAL;
        end
        ST_CAL: begin
          if (pfd_tick && cnt_zero) state <= ST_RESTORE;
        end
        ST_RESTORE: begin
          dbl_en     <= dbl_lat;
          sync_pulse <= 1'b1;
          hold_sync  <= 1'b0;
          state      <= ST_SYNC;
        end
        ST_SYNC: begin
          state <= ST_LOCK;
        end
        ST_LOCK: begin
          if (cnt_zero) begin
            cal_busy <= 1'b0;
            cal_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vco_cal_seq_chk.sv
module vco_cal_seq_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cal_req,
  input logic [DIV_W-1:0] cal_div,
  input logic             cal_busy,
  input logic             sync_pulse,
  input logic             hold_sync,
  input logic             cal_done
);
  a_r1_start_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> ($past(cal_req, 1) && !$past(cal_req, 2)));

  a_r2_div_stable_in_run: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && $past(cal_busy) && $past(cal_busy, 2)) |-> $stable(cal_div));

  a_r6_sync_single: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);

  a_r6_sync_in_run: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> cal_busy);

  a_r7_hold_stays_low: assert property (@(posedge clk) disable iff (rst)
    !hold_sync |=> !hold_sync);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> (!cal_busy && $past(cal_busy)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> !cal_done);
endmodule

bind vco_cal_seq vco_cal_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .cal_req(cal_req), .cal_div(cal_div), .cal_busy(cal_busy),
  .sync_pulse(sync_pulse), .hold_sync(hold_sync), .cal_done(cal_done)
);

// File: tb/vco_cal_seq_test.sv
module vco_cal_seq_test;
  localparam int N2_W = 8, M1_W = 3, LOCK_W = 8, T = 12, DIV_W = N2_W + M1_W + 1;

  logic clk = 1'b0, rst = 1'b1, cal_req = 1'b0, dbl_en_cfg = 1'b0, pfd_tick = 1'b1;
  logic [N2_W-1:0] n2_div = '0;
  logic [M1_W-1:0] m1_div = '0;
  logic [LOCK_W-1:0] lock_wait_cfg = '0;
  logic [DIV_W-1:0] cal_div;
  logic dbl_en, cal_busy, sync_pulse, hold_sync, cal_done;
  int checks = 0, fails = 0;

  always #2ns clk = ~clk;

  vco_cal_seq #(.N2_W(N2_W), .M1_W(M1_W), .CAL_TICKS(T), .LOCK_W(LOCK_W), .MIN_DIV(16)) uut (
    .clk(clk), .rst(rst), .cal_req(cal_req), .n2_div(n2_div), .m1_div(m1_div),
    .dbl_en_cfg(dbl_en_cfg), .pfd_tick(pfd_tick), .lock_wait_cfg(lock_wait_cfg),
    .cal_div(cal_div), .dbl_en(dbl_en), .cal_busy(cal_busy), .sync_pulse(sync_pulse),
    .hold_sync(hold_sync), .cal_done(cal_done)
  );

  function automatic logic exp_bypass(int n2, int m1, logic dbl);
    return dbl && (n2 * m1 < 16);
  endfunction

  function automatic int exp_div(int n2, int m1, logic dbl);
    return exp_bypass(n2, m1, dbl) ? 2 * n2 * m1 : n2 * m1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full run. stall: tick-free cycles inside the calibration phase.
  // mid: change settings during the run. retog: extra 0-to-1 edge during the run.
  task automatic run_cal(int n2, int m1, logic dbl, int lw, int stall, bit mid, bit retog);
    int endk, busy_n, sync_n, sync_k, done_n, done_k, div1;
    logic dbl_cal, dbl_rest;
    endk = T + lw + 4 + stall;
    busy_n = 0; sync_n = 0; sync_k = -1; done_n = 0; done_k = -1; div1 = -1;
    dbl_cal = 1'b0; dbl_rest = 1'b0;
    @(negedge clk);
    cal_req = 1'b0;
    @(negedge clk);
    n2_div = N2_W'(n2); m1_div = M1_W'(m1); dbl_en_cfg = dbl;
    lock_wait_cfg = LOCK_W'(lw); pfd_tick = 1'b1; cal_req = 1'b1;
    for (int k = 0; k <= endk + 3; k++) begin
      @(negedge clk);
      if (cal_busy) busy_n++;
      if (sync_pulse) begin sync_n++; sync_k = k; dbl_rest = dbl_en; end
      if (cal_done) begin done_n++; done_k = k; end
      if (k == 1) begin div1 = int'(cal_div); dbl_cal = dbl_en; end
      if (k == 0) check("R4 busy after edge", int'(cal_busy), 1);
      if (stall > 0 && k == 3) pfd_tick = 1'b0;
      if (stall > 0 && k == 3 + stall) pfd_tick = 1'b1;
      if (mid && k == 2) begin
        n2_div = N2_W'($urandom_range(1, 200)); m1_div = M1_W'($urandom_range(1, 7));
        dbl_en_cfg = ~dbl;
      end
      if (retog && k == 4) cal_req = 1'b0;
      if (retog && k == 6) cal_req = 1'b1;
    end
    check(mid ? "R10 div kept" : "R2 cal div", div1, exp_div(n2, m1, dbl));
    check("R3 doubler during cal", int'(dbl_cal), int'(dbl & ~exp_bypass(n2, m1, dbl)));
    check(mid ? "R10 doubler restored" : "R6 doubler restored", int'(dbl_rest), int'(dbl));
    check(retog ? "R1 ignored edge" : "R5 busy length", busy_n, endk);
    check("R6 sync count", sync_n, 1);
    check("R6 sync position", sync_k, T + 2 + stall);
    check("R9 done count", done_n, 1);
    check("R8 done position", done_k, endk);
    check("R7 hold low", int'(hold_sync), 0);
    cal_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cal_req = 1'b1;                       // held across reset: must not start (R1)
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 level at reset", int'(cal_busy), 0);
    check("R7 hold after reset", int'(hold_sync), 1);
    check("R9 reset done", int'(cal_done), 0);
    check("R6 reset sync", int'(sync_pulse), 0);
    check("R2 reset div", int'(cal_div), 0);
    dbl_en_cfg = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 idle follow", int'(dbl_en), 1);

    run_cal(10, 3, 1'b1, 3, 0, 1'b0, 1'b0);  // 30, no bypass
    run_cal(5, 3, 1'b1, 2, 0, 1'b0, 1'b0);   // 15 -> bypass, 30
    run_cal(4, 4, 1'b1, 0, 0, 1'b0, 1'b0);   // 16 boundary, no bypass
    run_cal(15, 1, 1'b0, 1, 0, 1'b0, 1'b0);  // 15 with doubler off
    run_cal(7, 2, 1'b1, 4, 30, 1'b0, 1'b0);  // tick stall, R5
    run_cal(3, 2, 1'b1, 2, 0, 1'b1, 1'b0);   // mid-run change, R10
    run_cal(20, 5, 1'b0, 2, 0, 1'b0, 1'b1);  // extra edge, R1
    check("R7 hold stays low", int'(hold_sync), 0);

    for (int i = 0; i < 10; i++)
      run_cal($urandom_range(0, 40), $urandom_range(1, 7), 1'($urandom_range(0, 1)),
              $urandom_range(0, 6), 0, 1'b0, 1'b0);

    dbl_en_cfg = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 idle follow low", int'(dbl_en), 0);
    dbl_en_cfg = 1'b1;
    @(negedge clk);
    check("R11 idle follow high", int'(dbl_en), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule